// File: doc/BRIEF.md
# Pin Mode and GPIO Register Bank

This block holds the per-pin configuration for 32 mixed-use pins. Each pin works as an analog converter input, a general-purpose input or a general-purpose output. The mode comes from two enable bits per pin. When neither bit is set, the pin is an analog input. When the output enable is set, the pin is an output, and this holds even if the input enable is also set. When only the input enable is set, the pin is an input.

The serial target logic presents byte-wide register writes and reads over a 4-bit offset. The two high offset bits select one of four groups: synchronised pin levels (read-only), input enables, output enables, and output levels. Within a group the two low offset bits select a byte of eight pins, and the banks run in reverse pin order. The block drives the output levels and output enables to the pads. It samples the pad levels through a two-flop synchroniser. For the converter datapath, it reports whether the channel being converted currently belongs to a GPIO pin, so that the conversion result can be flagged.

Top module: `pin_mode_regbank`

## Requirements
- R1: After reset, every input enable, output enable and output level bit is zero: pin_oe is 0, pin_out is 0, and all 32 pins are analog inputs.
- R2: Offset bits [3:2] select the group: 0 = pin levels, 1 = input enable, 2 = output enable, 3 = output level. Offset bits [1:0] = j address pins 8*(3-j) to 8*(3-j)+7, with pin n at data bit n mod 8. Offset 3 therefore holds pins 0..7 and offset 0 holds pins 24..31.
- R3: A write to an output-enable offset changes only that byte of pin_oe, and the change is visible one cycle after the write strobe. No other pin_oe byte changes.
- R4: A write to an output-level offset changes the matching byte of pin_out one cycle after the strobe.
- R5: When rd_en is high at a clock edge, rd_data takes the addressed register byte at that edge. Without rd_en, rd_data holds its value.
- R6: Pin levels pass through two flops before they can be read. A level change applied before edge k is returned by a read strobed at edge k+2 but not by a read at edge k or edge k+1.
- R7: Writes to pin-level offsets (offset bits [3:2] = 0) are ignored: no enable bit and no output level bit changes, and a later read still returns the pin levels.
- R8: adc_chan_is_gpio is high exactly when the input-enable bit or the output-enable bit of pin adc_chan is set. Channel n is pin n.
- R9: A pin with both enable bits set is an output (pin_oe high). A pin with only the input enable set does not drive its pad (pin_oe low).
- R10: Every register that can be written reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write offset |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read offset |
| rd_data | output | 8 | Read byte, registered on rd_en |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| adc_chan | input | 5 | Channel being converted |
| adc_chan_is_gpio | output | 1 | Selected channel is configured as GPIO |

## Verification
The embedded properties check the following on every cycle:
- configuration never moves without a write strobe;
- writes to the pin-level group leave all configuration untouched;
- an output-enable write lands in exactly the addressed byte;
- rd_data holds between read strobes;
- an enabled output always flags its channel as GPIO.

Only the bench scenarios can show the following:
- that the reversed bank order puts each byte on the intended pins;
- the exact two-edge latency of the input synchroniser;
- the output-priority case where both enables are set;
- full readback of every group.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  localparam int BYTE_W = 8;
  localparam int GRP_W  = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_PIN_LVL = 2'd0,
    GRP_IN_EN   = 2'd1,
    GRP_OUT_EN  = 2'd2,
    GRP_OUT_LVL = 2'd3
  } pmux_grp_e;
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/pmux_cfg_regs.sv
module pmux_cfg_regs
  import pmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int NUM_BANKS = NUM_PINS / BYTE_W,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  pmux_grp_e           wr_grp,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] in_en_o,
  output logic [NUM_PINS-1:0] out_en_o,
  output logic [NUM_PINS-1:0] out_lvl_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              sel_bank;
    logic              ce_ie, ce_oe, ce_ol;
    logic [BYTE_W-1:0] ie_q, oe_q, ol_q;
    logic [BYTE_W-1:0] ie_d, oe_d, ol_d;

    always_comb begin
      sel_bank = wr_en && (wr_bank == BANK_W'(b));
      ce_ie    = sel_bank && (wr_grp == GRP_IN_EN);
      ce_oe    = sel_bank && (wr_grp == GRP_OUT_EN);
      ce_ol    = sel_bank && (wr_grp == GRP_OUT_LVL);
      ie_d     = wr_data;
      oe_d     = wr_data;
      ol_d     = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ie_q <= '0;
        oe_q <= '0;
        ol_q <= '0;
      end else begin
        if (ce_ie) ie_q <= ie_d;
        if (ce_oe) oe_q <= oe_d;
        if (ce_ol) ol_q <= ol_d;
      end
    end

    assign in_en_o [b*BYTE_W +: BYTE_W] = ie_q;
    assign out_en_o[b*BYTE_W +: BYTE_W] = oe_q;
    assign out_lvl_o[b*BYTE_W +: BYTE_W] = ol_q;
  end

  // R7: a write aimed at the read-only level group changes no configuration
  a_r7_lvl_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grp == GRP_PIN_LVL) |=>
      ($stable(in_en_o) && $stable(out_en_o) && $stable(out_lvl_o)));

  // R3: configuration moves only under a write strobe
  a_r3_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(in_en_o) && $stable(out_en_o) && $stable(out_lvl_o)));

  // R3: an output-enable write lands in the addressed byte
  a_r3_oe_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grp == GRP_OUT_EN) |=>
      (out_en_o[BYTE_W*$past(wr_bank) +: BYTE_W] == $past(wr_data)));
endmodule

// File: rtl/pmux_rd_mux.sv
module pmux_rd_mux
  import pmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int NUM_BANKS = NUM_PINS / BYTE_W,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  pmux_grp_e           grp,
  input  logic [BANK_W-1:0]   bank,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] in_en_i,
  input  logic [NUM_PINS-1:0] out_en_i,
  input  logic [NUM_PINS-1:0] out_lvl_i,
  output logic [BYTE_W-1:0]   byte_o
);
  logic [NUM_PINS-1:0] vec;

  always_comb begin
    unique case (grp)
      GRP_PIN_LVL: vec = lvl_i;
      GRP_IN_EN:   vec = in_en_i;
      GRP_OUT_EN:  vec = out_en_i;
      default:     vec = out_lvl_i;
    endcase
    byte_o = vec[BYTE_W*bank +: BYTE_W];
  end
endmodule

// File: rtl/pin_mode_regbank.sv
module pin_mode_regbank
  import pmux_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int NUM_BANKS = NUM_PINS / BYTE_W,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ADDR_W = GRP_W + BANK_W,
  localparam int CHAN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  input  logic [CHAN_W-1:0]   adc_chan,
  output logic                adc_chan_is_gpio
);
  localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_BANKS - 1);

  pmux_grp_e           wr_grp, rd_grp;
  logic [BANK_W-1:0]   wr_bank, rd_bank;
  logic [NUM_PINS-1:0] lvl_sync, in_en, out_en, out_lvl;
  logic [BYTE_W-1:0]   rd_byte, rd_data_d, rd_data_q;

  // Bank order is reversed: low offsets hold the high pins
  always_comb begin
    wr_grp  = pmux_grp_e'(wr_addr[ADDR_W-1 -: GRP_W]);
    rd_grp  = pmux_grp_e'(rd_addr[ADDR_W-1 -: GRP_W]);
    wr_bank = TOP_BANK - wr_addr[BANK_W-1:0];
    rd_bank = TOP_BANK - rd_addr[BANK_W-1:0];
  end

  pmux_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_in),
    .sync_o (lvl_sync)
  );

  pmux_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_grp   (wr_grp),
    .wr_bank  (wr_bank),
    .wr_data  (wr_data),
    .in_en_o  (in_en),
    .out_en_o (out_en),
    .out_lvl_o(out_lvl)
  );

  pmux_rd_mux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .grp      (rd_grp),
    .bank     (rd_bank),
    .lvl_i    (lvl_sync),
    .in_en_i  (in_en),
    .out_en_i (out_en),
    .out_lvl_i(out_lvl),
    .byte_o   (rd_byte)
  );

  always_comb rd_data_d = rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_d;
  end

  assign rd_data          = rd_data_q;
  assign pin_out          = out_lvl;
  assign pin_oe           = out_en;   // output enable wins over input enable
  assign adc_chan_is_gpio = in_en[adc_chan] | out_en[adc_chan];

  // R5: read data holds between strobes
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8/R9: an enabled output pin is always reported as a GPIO channel
  a_r8_oe_flags_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[adc_chan] |-> adc_chan_is_gpio);
endmodule

// File: tb/pin_mode_regbank_bench.sv
module pin_mode_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [31:0] pin_in, pin_out, pin_oe;
  logic [4:0]  adc_chan;
  logic        adc_chan_is_gpio;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_ie, m_oe, m_ol, m_lvl;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  pin_mode_regbank u_pin_mode_regbank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .adc_chan(adc_chan), .adc_chan_is_gpio(adc_chan_is_gpio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(input logic [3:0] off);
    int bank = 3 - int'(off[1:0]);
    case (off[3:2])
      2'd0:    return m_lvl[8*bank +: 8];
      2'd1:    return m_ie[8*bank +: 8];
      2'd2:    return m_oe[8*bank +: 8];
      default: return m_ol[8*bank +: 8];
    endcase
  endfunction

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    int bank = 3 - int'(off[1:0]);
    wr_en = 1'b1; wr_addr = off; wr_data = d;
    case (off[3:2])
      2'd1: m_ie[8*bank +: 8] = d;
      2'd2: m_oe[8*bank +: 8] = d;
      2'd3: m_ol[8*bank +: 8] = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares it
  task automatic rd(input logic [3:0] off, input logic [7:0] exp, input string req);
    rd_en = 1'b1; rd_addr = off;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_model(input logic [3:0] off, input string req);
    rd(off, model_byte(off), req);
  endtask

  // monitor
  initial begin
    forever begin
      bit hit;
      @(posedge clk);
      hit = rd_en && rst_n;
      @(negedge clk);
      if (hit) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, rd_data}, {24'd0, e});
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    pin_in = '0; adc_chan = '0;
    m_ie = '0; m_oe = '0; m_ol = '0; m_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    check("R1 flag", {31'd0, adc_chan_is_gpio}, 32'd0);
    for (int i = 0; i < 16; i++) rd_model(4'(i), "R1 reset readback");

    // R2/R3: output enables, pins 0..7 at offset 0xB, pins 24..31 at 0x8
    wr(4'hB, 8'h5A);
    check("R3 oe low byte", pin_oe, 32'h0000_005A);
    wr(4'h8, 8'h81);
    check("R2 R3 oe top byte", pin_oe, 32'h8100_005A);

    // R4: output levels, pins 8..15 at offset 0xE
    wr(4'hE, 8'hC3);
    check("R4 pin_out", pin_out, 32'h0000_C300);

    // R9: inputs on pins 16..23, outputs on 16..19 as well
    wr(4'h5, 8'hFF);
    check("R9 input enable drives nothing", pin_oe, 32'h8100_005A);
    wr(4'h9, 8'h0F);
    check("R9 output priority", pin_oe, 32'h810F_005A);

    // R8 channel flag
    adc_chan = 5'd16; #1 check("R8 ch16", {31'd0, adc_chan_is_gpio}, 32'd1);
    adc_chan = 5'd22; #1 check("R8 ch22 input", {31'd0, adc_chan_is_gpio}, 32'd1);
    adc_chan = 5'd8;  #1 check("R8 ch8 adc", {31'd0, adc_chan_is_gpio}, 32'd0);
    adc_chan = 5'd1;  #1 check("R8 ch1 out", {31'd0, adc_chan_is_gpio}, 32'd1);
    adc_chan = 5'd0;  #1 check("R8 ch0 adc", {31'd0, adc_chan_is_gpio}, 32'd0);
    adc_chan = 5'd31; #1 check("R8 ch31 out", {31'd0, adc_chan_is_gpio}, 32'd1);
    @(negedge clk);

    // R10 readback of written groups
    for (int i = 4; i < 16; i++) rd_model(4'(i), "R10 readback");

    // R6 synchroniser latency on pins 0..7 (offset 3)
    pin_in = 32'hA5C3_7E96;
    rd(4'h3, 8'h00, "R6 edge k");
    rd(4'h3, 8'h00, "R6 edge k+1");
    rd(4'h3, 8'h96, "R6 edge k+2");
    m_lvl = 32'hA5C3_7E96;
    for (int i = 0; i < 4; i++) rd_model(4'(i), "R2 R6 level banks");

    // R7 writes to level group ignored
    wr(4'h2, 8'hFF);
    wr(4'h0, 8'h00);
    check("R7 oe unchanged", pin_oe, 32'h810F_005A);
    check("R7 out unchanged", pin_out, 32'h0000_C300);
    rd_model(4'h2, "R7 level still pins");
    rd_model(4'h6, "R7 input enables unchanged");

    // R5 hold without strobe
    repeat (3) @(negedge clk);
    check("R5 rd_data hold", {24'd0, rd_data}, {24'd0, model_byte(4'h6)});

    // R4 overwrite all output levels
    wr(4'hF, 8'h01); wr(4'hC, 8'h80);
    check("R4 pin_out rewrite", pin_out, 32'h8000_C301);
    rd_model(4'hC, "R10 out level readback");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule